// File: doc/BRIEF.md
# Hidden Management Memory Window Router

This block sits in the memory decode path and decides, for every access, which target serves it. Each access arrives with an address, a valid strobe, a read/write flag and a flag that says whether the requester is currently running in management mode. One clock later the block reports a routing outcome. The access can go to the hidden management memory, to the normal target (video memory or DRAM), or be blocked. For a blocked access the block also reports that read data must be forced to all ones, or that the write must be dropped.

Two windows can hold hidden memory. One is the fixed legacy segment from 0xA0000 to 0xBFFFF. The other is a relocatable region near the top of DRAM, set by a base register and a size register. A control register holds the window enables and the open, close and lock bits. Firmware programs the windows during boot, then sets lock. From then until reset the window layout and the open bit cannot change. When the requester leaves management mode, routing falls back to the hidden state at once, because the decision comes from the mode flag on each access and needs no register write.

Top module: `smram_route_top`

## Requirements
- R1: After synchronous reset, both windows are disabled, open, close and lock are 0, the error bit is 0 and out_valid is 0. Every access then routes to the normal target (route code 0).
- R2: Results are registered. An access presented in cycle N produces out_valid in cycle N+1, and out_valid is 0 in the cycle after a cycle with no access.
- R3: An address that falls in no enabled window routes to the normal target (code 0) in either mode. The legacy window is 0xA0000..0xBFFFF inclusive. The top window is base <= addr < base+size.
- R4: A legacy-window access in management mode routes to hidden memory (code 1). If the close bit is set, it routes to the normal target (code 0) instead.
- R5: A legacy-window access outside management mode routes to the normal target (code 0). If the open bit is set, it routes to hidden memory (code 1).
- R6: A top-window access in management mode routes to hidden memory (code 1). Outside management mode it is blocked (code 2), unless the open bit is set, in which case it routes to hidden memory (code 1).
- R7: A blocked read raises out_rd_ones and a blocked write raises out_wr_drop. Neither flag is raised for an access that is not blocked.
- R8: A control write (cfg_sel 0) with open (bit 0) and close (bit 1) both set changes nothing, and it sets cfg_err. cfg_err stays set until reset.
- R9: Writing lock (bit 2) sets it for good and forces open to 0. The legacy enable (bit 3) and top enable (bit 4) in that same write still take effect. While locked, writes to open, lock, the enables, base (cfg_sel 1) and size (cfg_sel 2) are ignored, and only close can still be written.
- R10: Leaving management mode needs no register write. A top-window access that routed hidden in management mode is blocked on the next access made outside management mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select: 0 control, 1 top base, 2 top size |
| cfg_wdata | input | ADDR_W | Configuration write data |
| acc_valid | input | 1 | Access strobe |
| acc_addr | input | ADDR_W | Access physical address |
| acc_write | input | 1 | 1 for write, 0 for read |
| acc_smm | input | 1 | Requester is in management mode |
| out_valid | output | 1 | Routing result valid |
| out_route | output | 2 | 0 normal, 1 hidden, 2 blocked |
| out_rd_ones | output | 1 | Blocked read: return all ones |
| out_wr_drop | output | 1 | Blocked write: discard |
| cfg_err | output | 1 | Sticky illegal open-and-close write flag |

## Verification
The bench probes both edges of each window: 0x9FFFF and 0xC0000 around the legacy segment, and base+size-1 and base+size around the top window. An off-by-one compare would route one of these wrongly. It switches the mode flag between two back-to-back accesses to the same address, which catches a design that latches the mode instead of using it per access. It then writes illegal open-and-close patterns, sets lock while open is requested, and tries base, enable and open writes after lock. A design that lets any of these through shows open reachable, or a window that moved or vanished, in the routes that follow.

// File: rtl/smram_pkg.sv
package smram_pkg;
  typedef enum logic [1:0] {
    RT_NORMAL  = 2'd0,
    RT_HIDDEN  = 2'd1,
    RT_BLOCKED = 2'd2
  } route_e;

  localparam int unsigned CB_OPEN  = 0;
  localparam int unsigned CB_CLOSE = 1;
  localparam int unsigned CB_LOCK  = 2;
  localparam int unsigned CB_LEGEN = 3;
  localparam int unsigned CB_TOPEN = 4;

  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_BASE = 2'd1;
  localparam logic [1:0] SEL_SIZE = 2'd2;
endpackage

// File: rtl/smram_cfg_regs.sv
module smram_cfg_regs
  import smram_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [1:0]        sel,
  input  logic [ADDR_W-1:0] wdata,
  output logic              open_q,
  output logic              close_q,
  output logic              lock_q,
  output logic              leg_en_q,
  output logic              top_en_q,
  output logic [ADDR_W-1:0] base_q,
  output logic [ADDR_W-1:0] size_q,
  output logic              err_q
);
  logic illegal;
  assign illegal = wdata[CB_OPEN] & wdata[CB_CLOSE];

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q   <= 1'b0;
      close_q  <= 1'b0;
      lock_q   <= 1'b0;
      leg_en_q <= 1'b0;
      top_en_q <= 1'b0;
      base_q   <= '0;
      size_q   <= '0;
      err_q    <= 1'b0;
    end else if (we) begin
      case (sel)
        SEL_CTRL: begin
          if (illegal) begin
            err_q <= 1'b1;
          end else begin
            close_q <= wdata[CB_CLOSE];
            if (!lock_q) begin
              leg_en_q <= wdata[CB_LEGEN];
              top_en_q <= wdata[CB_TOPEN];
              lock_q   <= wdata[CB_LOCK];
              open_q   <= wdata[CB_LOCK] ? 1'b0 : wdata[CB_OPEN];
            end
          end
        end
        SEL_BASE: if (!lock_q) base_q <= wdata;
        SEL_SIZE: if (!lock_q) size_q <= wdata;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/smram_window_match.sv
module smram_window_match #(
  parameter int unsigned    ADDR_W = 32,
  parameter logic [ADDR_W-1:0] LEG_LO = ADDR_W'('hA0000),
  parameter logic [ADDR_W-1:0] LEG_HI = ADDR_W'('hBFFFF)
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              leg_en,
  input  logic              top_en,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] size,
  output logic              hit_leg,
  output logic              hit_top
);
  localparam int unsigned EW = ADDR_W + 1;
  logic [EW-1:0] addr_x, base_x, end_x;

  always_comb begin
    addr_x  = {1'b0, addr};
    base_x  = {1'b0, base};
    end_x   = base_x + {1'b0, size};
    hit_leg = leg_en && (addr >= LEG_LO) && (addr <= LEG_HI);
    hit_top = top_en && (addr_x >= base_x) && (addr_x < end_x);
  end
endmodule

// File: rtl/smram_route_logic.sv
module smram_route_logic
  import smram_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       valid,
  input  logic       write,
  input  logic       smm,
  input  logic       hit_leg,
  input  logic       hit_top,
  input  logic       open_q,
  input  logic       close_q,
  output logic       out_valid,
  output logic [1:0] out_route,
  output logic       out_rd_ones,
  output logic       out_wr_drop
);
  route_e nxt;

  always_comb begin
    if (hit_leg) begin
      if (smm) nxt = close_q ? RT_NORMAL : RT_HIDDEN;
      else     nxt = open_q  ? RT_HIDDEN : RT_NORMAL;
    end else if (hit_top) begin
      if (smm || open_q) nxt = RT_HIDDEN;
      else               nxt = RT_BLOCKED;
    end else begin
      nxt = RT_NORMAL;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_route   <= RT_NORMAL;
      out_rd_ones <= 1'b0;
      out_wr_drop <= 1'b0;
    end else begin
      out_valid   <= valid;
      out_route   <= nxt;
      out_rd_ones <= valid && (nxt == RT_BLOCKED) && !write;
      out_wr_drop <= valid && (nxt == RT_BLOCKED) && write;
    end
  end
endmodule

// File: rtl/smram_route_top.sv
module smram_route_top #(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_write,
  input  logic              acc_smm,
  output logic              out_valid,
  output logic [1:0]        out_route,
  output logic              out_rd_ones,
  output logic              out_wr_drop,
  output logic              cfg_err
);
  logic              open_q, close_q, lock_q, leg_en_q, top_en_q;
  logic [ADDR_W-1:0] base_q, size_q;
  logic              hit_leg, hit_top;

  smram_cfg_regs #(.ADDR_W(ADDR_W)) cfg_i (
    .clk(clk), .rst(rst), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
    .open_q(open_q), .close_q(close_q), .lock_q(lock_q),
    .leg_en_q(leg_en_q), .top_en_q(top_en_q),
    .base_q(base_q), .size_q(size_q), .err_q(cfg_err)
  );

  smram_window_match #(.ADDR_W(ADDR_W)) match_i (
    .addr(acc_addr), .leg_en(leg_en_q), .top_en(top_en_q),
    .base(base_q), .size(size_q), .hit_leg(hit_leg), .hit_top(hit_top)
  );

  smram_route_logic route_i (
    .clk(clk), .rst(rst), .valid(acc_valid), .write(acc_write), .smm(acc_smm),
    .hit_leg(hit_leg), .hit_top(hit_top), .open_q(open_q), .close_q(close_q),
    .out_valid(out_valid), .out_route(out_route),
    .out_rd_ones(out_rd_ones), .out_wr_drop(out_wr_drop)
  );
endmodule

// File: rtl/smram_route_chk.sv
module smram_route_chk #(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_we,
  input logic [1:0]        cfg_sel,
  input logic [ADDR_W-1:0] cfg_wdata,
  input logic              acc_valid,
  input logic              acc_smm,
  input logic              out_valid,
  input logic [1:0]        out_route,
  input logic              out_rd_ones,
  input logic              out_wr_drop,
  input logic              cfg_err,
  input logic              open_q,
  input logic              lock_q,
  input logic [ADDR_W-1:0] base_q
);
  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (rst)
    acc_valid |=> out_valid);
  assert_idle_follows_R2: assert property (@(posedge clk) disable iff (rst)
    !acc_valid |=> !out_valid);
  assert_no_hidden_outside_R5: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !acc_smm && !open_q) |=> (out_route != 2'd1));
  assert_blocked_flag_R7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_route == 2'd2) |-> (out_rd_ones ^ out_wr_drop));
  assert_unblocked_noflag_R7: assert property (@(posedge clk) disable iff (rst)
    !(out_valid && out_route == 2'd2) |-> !(out_rd_ones || out_wr_drop));
  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    cfg_err |=> cfg_err);
  assert_err_set_R8: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_sel == 2'd0 && cfg_wdata[0] && cfg_wdata[1]) |=> cfg_err);
  assert_lock_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    lock_q |=> lock_q);
  assert_lock_closes_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(lock_q) |-> !open_q);
  assert_locked_base_R9: assert property (@(posedge clk) disable iff (rst)
    lock_q |=> $stable(base_q));
endmodule

bind smram_route_top smram_route_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
  .acc_valid(acc_valid), .acc_smm(acc_smm), .out_valid(out_valid),
  .out_route(out_route), .out_rd_ones(out_rd_ones), .out_wr_drop(out_wr_drop),
  .cfg_err(cfg_err), .open_q(open_q), .lock_q(lock_q), .base_q(base_q)
);

// File: tb/smram_route_tb.sv
`timescale 1ns/1ps
module smram_route_top_tb_top;
  localparam int unsigned AW = 32;
  localparam logic [AW-1:0] TBASE = 32'h7F00_0000;
  localparam logic [AW-1:0] TSIZE = 32'h0100_0000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_we = 1'b0;
  logic [1:0]    cfg_sel = 2'd0;
  logic [AW-1:0] cfg_wdata = '0;
  logic          acc_valid = 1'b0;
  logic [AW-1:0] acc_addr = '0;
  logic          acc_write = 1'b0;
  logic          acc_smm = 1'b0;
  logic          out_valid, out_rd_ones, out_wr_drop, cfg_err;
  logic [1:0]    out_route;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  smram_route_top #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_write(acc_write),
    .acc_smm(acc_smm), .out_valid(out_valid), .out_route(out_route),
    .out_rd_ones(out_rd_ones), .out_wr_drop(out_wr_drop), .cfg_err(cfg_err)
  );

  typedef struct {
    logic [1:0] route;
    logic       ones;
    logic       drop;
    string      tag;
  } exp_t;
  exp_t sb[$];

  // bench model of configuration
  logic m_open = 0, m_close = 0, m_lock = 0, m_leg = 0, m_top = 0, m_err = 0;
  logic [AW-1:0] m_base = '0, m_size = '0;

  function automatic logic [1:0] model_route(logic [AW-1:0] a, logic smm);
    logic leg, top;
    leg = m_leg && a >= 32'h000A_0000 && a <= 32'h000B_FFFF;
    top = m_top && ({1'b0, a} >= {1'b0, m_base}) &&
          ({1'b0, a} < ({1'b0, m_base} + {1'b0, m_size}));
    if (leg) return smm ? (m_close ? 2'd0 : 2'd1) : (m_open ? 2'd1 : 2'd0);
    if (top) return (smm || m_open) ? 2'd1 : 2'd2;
    return 2'd0;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic access(logic [AW-1:0] a, logic smm, logic wr, string tag);
    exp_t e;
    @(negedge clk);
    acc_valid = 1'b1; acc_addr = a; acc_smm = smm; acc_write = wr;
    e.route = model_route(a, smm);
    e.ones  = (e.route == 2'd2) && !wr;
    e.drop  = (e.route == 2'd2) && wr;
    e.tag   = tag;
    sb.push_back(e);
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  task automatic cfg_write(logic [1:0] sel, logic [AW-1:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    if (sel == 2'd0) begin
      if (d[0] && d[1]) m_err = 1'b1;
      else begin
        m_close = d[1];
        if (!m_lock) begin
          m_leg = d[3]; m_top = d[4]; m_lock = d[2];
          m_open = d[2] ? 1'b0 : d[0];
        end
      end
    end else if (sel == 2'd1) begin
      if (!m_lock) m_base = d;
    end else if (sel == 2'd2) begin
      if (!m_lock) m_size = d;
    end
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // monitor
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (sb.size() == 0) begin
        checks++; errors++;
        $display("FAIL R2 unexpected result actual=1 expected=0");
      end else begin
        exp_t e;
        e = sb.pop_front();
        check({e.tag, " route"}, 32'(out_route), 32'(e.route));
        check({e.tag, "/R7 rd_ones"}, 32'(out_rd_ones), 32'(e.ones));
        check({e.tag, "/R7 wr_drop"}, 32'(out_wr_drop), 32'(e.drop));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    check("R1 out_valid", 32'(out_valid), 0);
    check("R1 cfg_err", 32'(cfg_err), 0);
    access(32'h000A_0000, 1'b1, 1'b0, "R1");
    access(TBASE, 1'b0, 1'b0, "R1");

    cfg_write(2'd1, TBASE);
    cfg_write(2'd2, TSIZE);
    cfg_write(2'd0, 32'h18);
    access(32'h0009_FFFF, 1'b1, 1'b0, "R3");
    access(32'h000A_0000, 1'b1, 1'b0, "R4");
    access(32'h000B_FFFF, 1'b1, 1'b1, "R4");
    access(32'h000C_0000, 1'b1, 1'b0, "R3");
    access(32'h000A_0000, 1'b0, 1'b0, "R5");
    access(TBASE, 1'b0, 1'b0, "R6");
    access(TBASE + TSIZE - 1, 1'b0, 1'b1, "R6");
    access(TBASE + TSIZE, 1'b0, 1'b0, "R3");
    access(TBASE - 1, 1'b1, 1'b0, "R3");
    access(TBASE + 32'h10, 1'b1, 1'b1, "R10");
    access(TBASE + 32'h10, 1'b0, 1'b1, "R10");

    cfg_write(2'd0, 32'h19);
    access(32'h000B_0000, 1'b0, 1'b0, "R5");
    access(TBASE, 1'b0, 1'b1, "R6");

    cfg_write(2'd0, 32'h1B);
    check("R8 cfg_err", 32'(cfg_err), 1);
    access(32'h000A_0000, 1'b0, 1'b0, "R8");
    cfg_write(2'd0, 32'h1A);
    access(32'h000A_0000, 1'b1, 1'b0, "R4");

    cfg_write(2'd0, 32'h1D);
    access(TBASE, 1'b0, 1'b0, "R9");
    access(32'h000A_0000, 1'b0, 1'b0, "R9");
    check("R8 cfg_err sticky", 32'(cfg_err), 1);
    cfg_write(2'd0, 32'h02);
    access(32'h000A_0000, 1'b1, 1'b0, "R9");
    cfg_write(2'd0, 32'h01);
    access(TBASE, 1'b0, 1'b1, "R9");
    access(32'h000A_0000, 1'b0, 1'b0, "R9");
    cfg_write(2'd1, 32'h0);
    cfg_write(2'd2, 32'h0010_0000);
    access(32'h0000_0100, 1'b0, 1'b0, "R9");
    access(TBASE + TSIZE - 1, 1'b0, 1'b0, "R9");
    cfg_write(2'd0, 32'h00);
    access(TBASE, 1'b0, 1'b0, "R9");
    access(32'h000B_FFFF, 1'b1, 1'b0, "R9");

    repeat (3) @(negedge clk);
    check("R2 scoreboard drained", 32'(sb.size()), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule